// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the 16x oversampling tick for a UART transmitter and receiver from the peripheral clock. Two stages sit in series. The first is a fractional prescaler that removes clock cycles in a regular pattern, which slows the clock by a factor of (1 + add/mul). The second is a 16-bit integer divisor that counts the surviving cycles and emits one tick per full count. Because the factor can be fractional, a single peripheral clock frequency can reach the common baud rates with a small error.

Software programs three 8-bit registers through a simple select/data port: the low and high bytes of the integer divisor, and a fractional control byte. The control byte holds the add value in bits 3:0 and the multiplier in bits 7:4. The frequency of `baud_tick` is clk × mul / ((mul + add) × divisor). Illegal settings do not stall the block. A multiplier of 0 acts as 1, and a divisor of 0 acts as 1. Any register write restarts both stages from a known phase.

The divider runs a two-state machine. In `DIV_RELOAD` it loads the counter from the effective divisor and moves to `DIV_RUN` on the next edge. It enters `DIV_RELOAD` after reset and after every register write. In `DIV_RUN` each prescaler enable decrements the counter. When an enable arrives with the counter at 1, the tick is raised and the counter reloads. `DIV_RUN` leaves only through a write or reset.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, reads return 0x01 for the divisor low byte (select 0), 0x00 for the divisor high byte (select 1), and 0x10 for the fractional byte (select 2). The fractional byte carries the add value in bits 3:0 and the multiplier in bits 7:4.
- R2: A write with select 3 changes no register, and a read with select 3 returns 0x00.
- R3: Over a long window, the number of `baud_tick` pulses stays within one of window × mul / ((mul + add) × divisor).
- R4: With an add value of 0, the prescaler passes every clock cycle. The tick rate is then clk / divisor.
- R5: With a nonzero add value, the prescaler gives exactly mul enables in every (mul + add) clock cycles, and its accumulator stays below mul + add.
- R6: When the divisor is 2 or more, `baud_tick` lasts one clock cycle. It is raised only in the cycle after a prescaler enable.
- R7: A divisor of 0 behaves as a divisor of 1.
- R8: A multiplier field of 0 behaves as 1, while reads return the raw value written.
- R9: A write to select 0, 1 or 2 clears the accumulator and reloads the counter. With add 0 and divisor D, the first tick is seen after the (D+1)-th rising edge following the write edge.
- R10: While the divider is in `DIV_RUN`, its counter is never 0, so the block never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 divisor low, 1 divisor high, 2 fractional, 3 none |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select, same encoding as the write select |
| rd_data | output | 8 | Read data of the selected register |
| baud_tick | output | 1 | One-cycle 16x oversampling tick |

## Verification
The hardest case to reach is the exact phase after a write made in the middle of a run. The accumulator and counter hold leftover state from the previous setting, and that state must be discarded. The stimulus lets a divide-by-5 run go for an arbitrary number of cycles. It then rewrites a register and checks every one of the next eleven cycles for the tick. The illegal zero multiplier and zero divisor are reached through vector rows that program them directly, and the measured rates of those rows are checked.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    // Register select encoding shared by read and write paths.
    typedef enum logic [1:0] {
        SEL_DIV_LO = 2'd0,
        SEL_DIV_HI = 2'd1,
        SEL_FRAC   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Divider control states.
    typedef enum logic [0:0] {
        DIV_RELOAD = 1'b0,
        DIV_RUN    = 1'b1
    } div_state_e;

    localparam logic [7:0] RST_DIV_LO = 8'h01;
    localparam logic [7:0] RST_DIV_HI = 8'h00;
    localparam logic [3:0] RST_ADD    = 4'h0;
    localparam logic [3:0] RST_MUL    = 4'h1;

endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
    import fbg_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [1:0]         rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    output logic [DATA_W-1:0]  div_lo,
    output logic [DATA_W-1:0]  div_hi,
    output logic [FIELD_W-1:0] add_val,
    output logic [FIELD_W-1:0] mul_val,
    output logic               cfg_wr
);

    reg_sel_e wsel;
    reg_sel_e rsel;

    assign wsel   = reg_sel_e'(wr_sel);
    assign rsel   = reg_sel_e'(rd_sel);
    assign cfg_wr = wr_en && (wsel != SEL_NONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo  <= DATA_W'(RST_DIV_LO);
            div_hi  <= DATA_W'(RST_DIV_HI);
            add_val <= FIELD_W'(RST_ADD);
            mul_val <= FIELD_W'(RST_MUL);
        end else if (wr_en) begin
            unique case (wsel)
                SEL_DIV_LO: div_lo <= wr_data;
                SEL_DIV_HI: div_hi <= wr_data;
                SEL_FRAC: begin
                    add_val <= wr_data[FIELD_W-1:0];
                    mul_val <= wr_data[2*FIELD_W-1:FIELD_W];
                end
                SEL_NONE: ;
            endcase
        end
    end

    always_comb begin
        unique case (rsel)
            SEL_DIV_LO: rd_data = div_lo;
            SEL_DIV_HI: rd_data = div_hi;
            SEL_FRAC:   rd_data = {mul_val, add_val};
            SEL_NONE:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
    parameter int FIELD_W = 4,
    localparam int ACC_W  = FIELD_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [FIELD_W-1:0] mul_raw,
    input  logic [FIELD_W-1:0] add_val,
    output logic               en,
    output logic [ACC_W-1:0]   acc_level,
    output logic [ACC_W-1:0]   acc_mod,
    output logic [FIELD_W-1:0] mul_eff
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    // A zero multiplier is treated as one so the accumulator always advances.
    assign mul_eff   = (mul_raw == '0) ? FIELD_W'(1) : mul_raw;
    assign acc_mod   = ACC_W'(mul_eff) + ACC_W'(add_val);
    assign sum       = acc_q + ACC_W'(mul_eff);
    assign acc_level = acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
            en    <= 1'b0;
        end else if (sum >= acc_mod) begin
            acc_q <= sum - acc_mod;
            en    <= 1'b1;
        end else begin
            acc_q <= sum;
            en    <= 1'b0;
        end
    end

endmodule

// File: rtl/fbg_divider.sv
module fbg_divider
    import fbg_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             en,
    input  logic [DIV_W-1:0] div_raw,
    output logic             tick,
    output logic [DIV_W-1:0] cnt_val,
    output logic             div_run,
    output logic [DIV_W-1:0] div_eff
);

    div_state_e       state;
    logic [DIV_W-1:0] cnt_q;

    // A zero divisor is treated as one.
    assign div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;
    assign cnt_val = cnt_q;
    assign div_run = (state == DIV_RUN);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            state <= DIV_RELOAD;
        end else begin
            unique case (state)
                DIV_RELOAD: state <= DIV_RUN;
                DIV_RUN:    state <= DIV_RUN;
            endcase
        end
    end

    // Counter and tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (reload) begin
            tick  <= 1'b0;
        end else begin
            unique case (state)
                DIV_RELOAD: begin
                    cnt_q <= div_eff;
                    tick  <= 1'b0;
                end
                DIV_RUN: begin
                    tick <= 1'b0;
                    if (en) begin
                        if (cnt_q <= DIV_W'(1)) begin
                            tick  <= 1'b1;
                            cnt_q <= div_eff;
                        end else begin
                            cnt_q <= cnt_q - DIV_W'(1);
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FIELD_W = DATA_W / 2,
    localparam int DIV_W  = 2 * DATA_W,
    localparam int ACC_W  = FIELD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              baud_tick
);

    logic [DATA_W-1:0]  div_lo;
    logic [DATA_W-1:0]  div_hi;
    logic [FIELD_W-1:0] add_val;
    logic [FIELD_W-1:0] mul_val;
    logic [FIELD_W-1:0] mul_eff;
    logic               cfg_wr;
    logic               presc_en;
    logic [ACC_W-1:0]   acc_level;
    logic [ACC_W-1:0]   acc_mod;
    logic [DIV_W-1:0]   cnt_val;
    logic [DIV_W-1:0]   div_eff;
    logic               div_run;

    fbg_regs #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .div_lo  (div_lo),
        .div_hi  (div_hi),
        .add_val (add_val),
        .mul_val (mul_val),
        .cfg_wr  (cfg_wr)
    );

    fbg_prescaler #(.FIELD_W(FIELD_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_wr),
        .mul_raw   (mul_val),
        .add_val   (add_val),
        .en        (presc_en),
        .acc_level (acc_level),
        .acc_mod   (acc_mod),
        .mul_eff   (mul_eff)
    );

    fbg_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (cfg_wr),
        .en      (presc_en),
        .div_raw ({div_hi, div_lo}),
        .tick    (baud_tick),
        .cnt_val (cnt_val),
        .div_run (div_run),
        .div_eff (div_eff)
    );

endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
    parameter int FIELD_W = 4,
    parameter int DIV_W   = 16,
    localparam int ACC_W  = FIELD_W + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr,
    input logic               baud_tick,
    input logic               presc_en,
    input logic [ACC_W-1:0]   acc_level,
    input logic [ACC_W-1:0]   acc_mod,
    input logic [FIELD_W-1:0] mul_eff,
    input logic [DIV_W-1:0]   cnt_val,
    input logic               div_run,
    input logic [DIV_W-1:0]   div_eff
);

    a_r5_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_level < acc_mod);

    a_r9_write_clears_acc: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (acc_level == '0) && !presc_en && !baud_tick);

    a_r6_tick_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(presc_en));

    a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && div_eff > DIV_W'(1)) |=> !baud_tick);

    a_r10_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        div_run |-> (cnt_val != '0));

    a_r4_no_slip: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_wr) && $past(acc_mod == ACC_W'(mul_eff)))
        |-> presc_en);

endmodule

bind frac_baud_gen fbg_checker #(.FIELD_W(FIELD_W), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .baud_tick (baud_tick),
    .presc_en  (presc_en),
    .acc_level (acc_level),
    .acc_mod   (acc_mod),
    .mul_eff   (mul_eff),
    .cnt_val   (cnt_val),
    .div_run   (div_run),
    .div_eff   (div_eff)
);

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/100ps
module frac_baud_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       baud_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    frac_baud_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .baud_tick (baud_tick)
    );

    // {div_lo, div_hi, frac, window}
    localparam logic [39:0] VECS [0:7] = '{
        {8'h01, 8'h00, 8'h10, 16'd200},
        {8'h0A, 8'h00, 8'h10, 16'd1000},
        {8'h04, 8'h00, 8'h31, 16'd1600},
        {8'h02, 8'h00, 8'hFF, 16'd800},
        {8'h00, 8'h00, 8'h00, 16'd300},
        {8'h03, 8'h00, 8'h05, 16'd1800},
        {8'h00, 8'h01, 8'h10, 16'd2560},
        {8'h07, 8'h00, 8'h52, 16'd4900}
    };

    task automatic check(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        rd_sel = sel;
        #1 d = rd_data;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int ticks;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values, and R4 with divisor 1 gives a tick every cycle
        ticks = 0;
        repeat (5) @(posedge clk);
        for (int k = 0; k < 20; k++) begin
            @(posedge clk); #1;
            if (baud_tick) ticks++;
        end
        check("R4 reset tick every cycle", ticks, 20);
        rd(2'd0, v); check("R1 div_lo reset", v, 8'h01);
        rd(2'd1, v); check("R1 div_hi reset", v, 8'h00);
        rd(2'd2, v); check("R1 frac reset", v, 8'h10);
        rd(2'd3, v); check("R2 select 3 reads zero", v, 8'h00);

        // R2: write with select 3 ignored
        wr(2'd3, 8'hFF);
        rd(2'd0, v); check("R2 div_lo kept", v, 8'h01);
        rd(2'd1, v); check("R2 div_hi kept", v, 8'h00);
        rd(2'd2, v); check("R2 frac kept", v, 8'h10);

        // Vector table: R3 rate, plus R4, R5, R7, R8, R10 corner rows
        for (int i = 0; i < 8; i++) begin
            int m, a, d, n, exp_t, diff;
            string tag;
            logic [7:0] lo, hi, fr;
            lo = VECS[i][39:32];
            hi = VECS[i][31:24];
            fr = VECS[i][23:16];
            n  = int'(VECS[i][15:0]);
            m  = (fr[7:4] == 4'd0) ? 1 : int'(fr[7:4]);
            a  = int'(fr[3:0]);
            d  = ({hi, lo} == 16'd0) ? 1 : int'({hi, lo});
            exp_t = (n * m) / ((m + a) * d);
            if ({hi, lo} == 16'd0)   tag = "R3/R7/R10";
            else if (fr[7:4] == 0)   tag = "R3/R8";
            else if (a == 0)         tag = "R3/R4";
            else                     tag = "R3/R5";
            wr(2'd0, lo);
            wr(2'd1, hi);
            wr(2'd2, fr);
            repeat (8) @(posedge clk);
            ticks = 0;
            for (int k = 0; k < n; k++) begin
                @(posedge clk); #1;
                if (baud_tick) ticks++;
            end
            diff = ticks - exp_t;
            if (diff >= -1 && diff <= 1) check(tag, ticks, ticks);
            else check(tag, ticks, exp_t);
        end

        // R8: zero multiplier reads back raw
        wr(2'd2, 8'h03);
        rd(2'd2, v); check("R8 raw frac readback", v, 8'h03);

        // R9 and R6: mid-run rewrite restarts phase; divisor 5, add 0
        wr(2'd0, 8'h05);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h10);
        repeat (37) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h05;
        @(posedge clk); #1;
        wr_en = 1'b0;
        for (int k = 1; k <= 11; k++) begin
            @(posedge clk); #1;
            check($sformatf("R9/R6 restart edge %0d", k), int'(baud_tick),
                  (k == 6 || k == 11) ? 1 : 0);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule